// File: doc/BRIEF.md
# In-Order Retirement Buffer with Precise Traps

This block tracks instructions of an out-of-order core from entry to retirement. Instructions enter through a dispatch port in program order. Each one is given a slot in a circular buffer, and the slot index is returned as its tag. Execution units report results in any order through a completion port, which carries the tag, a result word and a fault flag. The result stays in the slot and does not reach architectural state yet.

Each cycle the oldest slot is examined. If it is finished, it retires into an architectural register file held inside the block. An instruction of mask-update kind does not write a register: on retirement it loads bit 0 of its result into the architectural trap-enable flag.

The decision to trap is made only at retirement. A faulting slot at the head is compared with the trap-enable flag as it stands at that moment. When traps are disabled, the slot retires normally. When traps are enabled, a trap is raised with the faulting tag, no register is written, and the buffer is emptied. As a result, an older mask update that completes late still governs whether a younger fault traps.

Top module: `inorder_retire_buf`

## Requirements
- R1: After reset the buffer is empty: `disp_full`=0, `disp_tag`=0, `cmt_valid`=0, `trap_o`=0. The trap-enable flag `trap_en_o` is 0 (traps disabled), and every architectural register reads 0.
- R2: An accepted dispatch takes the slot at `disp_tag`, and tags are handed out sequentially modulo DEPTH. Dispatch is accepted when `disp_valid`=1, `disp_full`=0 and no trap is raised in that cycle.
- R3: Once DEPTH slots are occupied, `disp_full`=1 and a further dispatch is ignored, so `disp_tag` does not move. Exactly DEPTH retirements then follow once all slots are completed.
- R4: A completed result is held in its slot. The architectural register does not change until that slot retires.
- R5: Only the head slot may retire, and only when it is completed. Completed younger slots wait behind an unfinished head. Completion never targets the slot that retires or traps in the same cycle.
- R6: A retiring register-kind slot (`disp_kind`=0) presents `cmt_valid`=1 with its tag, destination and result for one cycle, and writes the result to its destination register at the next edge. One slot retires per cycle at most.
- R7: A mask-kind slot (`disp_kind`=1) changes `trap_en_o` to bit 0 of its result only at the clock edge at which it retires. Completing such a slot alone leaves `trap_en_o` unchanged.
- R8: A faulting head slot that retires while `trap_en_o`=0 retires normally: `cmt_valid`=1, its result is written, and `trap_o`=0.
- R9: A faulting head slot with `trap_en_o`=1 raises `trap_o`=1 with `trap_tag` set to its tag and `cmt_valid`=0. It writes no register. In the next cycle the buffer is empty, tags restart at 0, and all younger slots are discarded without retiring.
- R10: A dispatch presented in the cycle a trap is raised is ignored.
- R11: A younger fault that completes before an older trap-enabling mask update traps once the mask update has retired ahead of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 1 | 0 = register write, 1 = trap-enable update |
| disp_dest | input | AREG_W | Destination architectural register |
| disp_full | output | 1 | All slots occupied |
| disp_tag | output | TAG_W | Tag given to the next dispatched instruction |
| cmp_valid | input | 1 | Completion report |
| cmp_tag | input | TAG_W | Slot being completed |
| cmp_data | input | DATA_W | Result word |
| cmp_fault | input | 1 | Execution fault seen |
| cmt_valid | output | 1 | Head slot retires this cycle |
| cmt_tag | output | TAG_W | Tag of retiring slot |
| cmt_dest | output | AREG_W | Destination of retiring slot |
| cmt_data | output | DATA_W | Result of retiring slot |
| trap_o | output | 1 | Precise trap raised this cycle |
| trap_tag | output | TAG_W | Tag of the faulting slot |
| trap_en_o | output | 1 | Architectural trap-enable flag |
| rd_addr | input | AREG_W | Architectural register read address |
| rd_data | output | DATA_W | Architectural register read data |

## Verification
The hardest case to reach is a younger fault that finishes first while an older trap-enabling update is still outstanding. The outcome then depends on retirement order and not on completion order. The stimulus dispatches the mask update, the faulting instruction and one more younger instruction. It completes the two younger ones first and the mask update last. The bench then checks that the flag flips only at the mask update's retirement edge, and that the trap follows in the very next cycle, discarding the already-completed younger slot. A full buffer that wraps its tags past DEPTH-1 and is completed in reverse order is the other case that needs deliberate setup.

// File: rtl/irb_pkg.sv
package irb_pkg;
   typedef enum logic {
      KIND_REG  = 1'b0,
      KIND_MASK = 1'b1
   } kind_e;

   typedef enum logic [1:0] {
      ACT_IDLE   = 2'd0,
      ACT_RETIRE = 2'd1,
      ACT_TRAP   = 2'd2
   } head_act_e;
endpackage

// File: rtl/irb_ptr_ctrl.sv
module irb_ptr_ctrl #(
   parameter int DEPTH = 8,
   localparam int TAG_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   output logic [TAG_W-1:0] head,
   output logic [TAG_W-1:0] tail,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (push) tail <= tail + 1'b1;
         if (pop)  head <= head + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign full  = (count == CNT_MAX);
   assign empty = (count == '0);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) count <= CNT_MAX); // R3
   AST_FULL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !flush) |=> $stable(tail)); // R3
   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !pop); // R5
endmodule

// File: rtl/irb_entry_store.sv
module irb_entry_store
   import irb_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 16,
   parameter int AREG_W = 3,
   localparam int TAG_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic [AREG_W-1:0] alloc_dest,
   input  kind_e             alloc_kind,
   input  logic              cmp_en,
   input  logic [TAG_W-1:0]  cmp_tag,
   input  logic [DATA_W-1:0] cmp_data,
   input  logic              cmp_fault,
   input  logic              free_en,
   input  logic [TAG_W-1:0]  rd_tag,
   input  logic              flush,
   output logic              hd_valid,
   output logic              hd_done,
   output logic              hd_fault,
   output kind_e             hd_kind,
   output logic [AREG_W-1:0] hd_dest,
   output logic [DATA_W-1:0] hd_data
);
   logic [DEPTH-1:0]  valid_q;
   logic [DEPTH-1:0]  done_q;
   logic [DEPTH-1:0]  fault_q;
   kind_e             kind_q [DEPTH];
   logic [AREG_W-1:0] dest_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(i);
      logic sel_alloc, sel_cmp, sel_free;
      assign sel_alloc = alloc_en && (alloc_tag == MY_TAG);
      assign sel_cmp   = cmp_en && (cmp_tag == MY_TAG) && valid_q[i];
      assign sel_free  = free_en && (rd_tag == MY_TAG);

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            valid_q[i] <= 1'b0;
            done_q[i]  <= 1'b0;
            fault_q[i] <= 1'b0;
         end else if (sel_alloc) begin
            valid_q[i] <= 1'b1;
            done_q[i]  <= 1'b0;
            fault_q[i] <= 1'b0;
         end else if (sel_free) begin
            valid_q[i] <= 1'b0;
            done_q[i]  <= 1'b0;
         end else if (sel_cmp) begin
            done_q[i]  <= 1'b1;
            fault_q[i] <= cmp_fault;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            kind_q[i] <= KIND_REG;
            dest_q[i] <= '0;
            data_q[i] <= '0;
         end else begin
            if (sel_alloc) begin
               kind_q[i] <= alloc_kind;
               dest_q[i] <= alloc_dest;
            end
            if (sel_cmp) data_q[i] <= cmp_data;
         end
      end
   end

   assign hd_valid = valid_q[rd_tag];
   assign hd_done  = done_q[rd_tag];
   assign hd_fault = fault_q[rd_tag];
   assign hd_kind  = kind_q[rd_tag];
   assign hd_dest  = dest_q[rd_tag];
   assign hd_data  = data_q[rd_tag];

   AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> !valid_q[alloc_tag]); // R2
   AST_DONE_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done_q & ~valid_q)  && ((done_q & ~valid_q) == '0)); // R4
endmodule

// File: rtl/irb_arch_state.sv
module irb_arch_state #(
   parameter int AREG_N = 8,
   parameter int DATA_W = 16,
   localparam int AREG_W = $clog2(AREG_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AREG_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              mask_we,
   input  logic              mask_val,
   input  logic [AREG_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              trap_en
);
   logic [DATA_W-1:0] regs_q [AREG_N];

   for (genvar r = 0; r < AREG_N; r++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)                                   regs_q[r] <= '0;
         else if (wr_en && (wr_addr == AREG_W'(r)))    regs_q[r] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       trap_en <= 1'b0;
      else if (mask_we) trap_en <= mask_val;
   end

   assign rd_data = regs_q[rd_addr];

   AST_MASK_ONLY_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_we |=> $stable(trap_en)); // R7
   AST_SINGLE_ARCH_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({wr_en, mask_we}) <= 1); // R6
endmodule

// File: rtl/inorder_retire_buf.sv
module inorder_retire_buf
   import irb_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 16,
   parameter int AREG_N = 8,
   localparam int TAG_W  = $clog2(DEPTH),
   localparam int AREG_W = $clog2(AREG_N),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   input  logic              disp_kind,
   input  logic [AREG_W-1:0] disp_dest,
   output logic              disp_full,
   output logic [TAG_W-1:0]  disp_tag,
   input  logic              cmp_valid,
   input  logic [TAG_W-1:0]  cmp_tag,
   input  logic [DATA_W-1:0] cmp_data,
   input  logic              cmp_fault,
   output logic              cmt_valid,
   output logic [TAG_W-1:0]  cmt_tag,
   output logic [AREG_W-1:0] cmt_dest,
   output logic [DATA_W-1:0] cmt_data,
   output logic              trap_o,
   output logic [TAG_W-1:0]  trap_tag,
   output logic              trap_en_o,
   input  logic [AREG_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (AREG_N < 2 || (AREG_N & (AREG_N - 1)) != 0) begin : g_bad_areg
      $error("AREG_N must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [TAG_W-1:0]  head, tail;
   logic [CNT_W-1:0]  count;
   logic              full, empty;
   logic              hd_valid, hd_done, hd_fault;
   kind_e             hd_kind;
   logic [AREG_W-1:0] hd_dest;
   logic [DATA_W-1:0] hd_data;
   logic              trap_en;
   head_act_e         act;
   logic              retire, trap, push;

   always_comb begin
      act = ACT_IDLE;
      if (hd_valid && hd_done) act = (hd_fault && trap_en) ? ACT_TRAP : ACT_RETIRE;
   end

   assign retire = (act == ACT_RETIRE);
   assign trap   = (act == ACT_TRAP);
   assign push   = disp_valid && !full && !trap;

   irb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(retire), .flush(trap),
      .head(head), .tail(tail), .count(count), .full(full), .empty(empty)
   );

   irb_entry_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AREG_W(AREG_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(push), .alloc_tag(tail), .alloc_dest(disp_dest), .alloc_kind(kind_e'(disp_kind)),
      .cmp_en(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_fault(cmp_fault),
      .free_en(retire), .rd_tag(head), .flush(trap),
      .hd_valid(hd_valid), .hd_done(hd_done), .hd_fault(hd_fault),
      .hd_kind(hd_kind), .hd_dest(hd_dest), .hd_data(hd_data)
   );

   irb_arch_state #(.AREG_N(AREG_N), .DATA_W(DATA_W)) u_arch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(retire && hd_kind == KIND_REG), .wr_addr(hd_dest), .wr_data(hd_data),
      .mask_we(retire && hd_kind == KIND_MASK), .mask_val(hd_data[0]),
      .rd_addr(rd_addr), .rd_data(rd_data), .trap_en(trap_en)
   );

   assign disp_full = full;
   assign disp_tag  = tail;
   assign cmt_valid = retire;
   assign cmt_tag   = head;
   assign cmt_dest  = hd_dest;
   assign cmt_data  = hd_data;
   assign trap_o    = trap;
   assign trap_tag  = head;
   assign trap_en_o = trap_en;

   AST_TRAP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      trap |=> (empty && tail == '0)); // R9
   AST_RETIRE_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (retire || trap) |-> !empty); // R5
   AST_NO_CMP_ON_HEAD_LEAVING: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && (retire || trap)) |-> (cmp_tag != head)); // R5
   AST_NO_PUSH_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      trap |=> (count == '0)); // R10
endmodule

// File: tb/inorder_retire_buf_tb_top.sv
module inorder_retire_buf_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TAG_W  = 3;
   localparam int AREG_W = 3;
   localparam int DATA_W = 16;
   localparam int WD_CYCLES = 5000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              disp_valid = 1'b0;
   logic              disp_kind = 1'b0;
   logic [AREG_W-1:0] disp_dest = '0;
   logic              disp_full;
   logic [TAG_W-1:0]  disp_tag;
   logic              cmp_valid = 1'b0;
   logic [TAG_W-1:0]  cmp_tag = '0;
   logic [DATA_W-1:0] cmp_data = '0;
   logic              cmp_fault = 1'b0;
   logic              cmt_valid;
   logic [TAG_W-1:0]  cmt_tag;
   logic [AREG_W-1:0] cmt_dest;
   logic [DATA_W-1:0] cmt_data;
   logic              trap_o;
   logic [TAG_W-1:0]  trap_tag;
   logic              trap_en_o;
   logic [AREG_W-1:0] rd_addr = '0;
   logic [DATA_W-1:0] rd_data;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   inorder_retire_buf dut_i (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_kind(disp_kind), .disp_dest(disp_dest),
      .disp_full(disp_full), .disp_tag(disp_tag),
      .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_fault(cmp_fault),
      .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_dest(cmt_dest), .cmt_data(cmt_data),
      .trap_o(trap_o), .trap_tag(trap_tag), .trap_en_o(trap_en_o),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_disp(input logic [AREG_W-1:0] dest, input logic kind, output logic [TAG_W-1:0] tag);
      disp_valid = 1'b1; disp_dest = dest; disp_kind = kind;
      #1 tag = disp_tag;
      @(negedge clk);
      disp_valid = 1'b0;
   endtask

   task automatic do_cmp(input logic [TAG_W-1:0] tag, input logic [DATA_W-1:0] data, input logic fault);
      cmp_valid = 1'b1; cmp_tag = tag; cmp_data = data; cmp_fault = fault;
      @(negedge clk);
      cmp_valid = 1'b0; cmp_fault = 1'b0;
   endtask

   task automatic read_reg(input logic [AREG_W-1:0] a, output int v);
      rd_addr = a;
      #1 v = int'(rd_data);
   endtask

   task automatic t_reset();
      int v;
      #1;
      check("R1", "disp_full", int'(disp_full), 0);
      check("R1", "disp_tag", int'(disp_tag), 0);
      check("R1", "cmt_valid", int'(cmt_valid), 0);
      check("R1", "trap_o", int'(trap_o), 0);
      check("R1", "trap_en_o", int'(trap_en_o), 0);
      for (int r = 0; r < 8; r++) begin
         read_reg(AREG_W'(r), v);
         check("R1", "reg value", v, 0);
      end
   endtask

   task automatic t_inorder();
      logic [TAG_W-1:0] t0, t1, t2;
      int v;
      do_disp(3'd1, 1'b0, t0);
      do_disp(3'd2, 1'b0, t1);
      do_disp(3'd3, 1'b0, t2);
      check("R2", "tag0", int'(t0), 0);
      check("R2", "tag1", int'(t1), 1);
      check("R2", "tag2", int'(t2), 2);
      do_cmp(t2, 16'h00A2, 1'b0);
      #1 check("R5", "no retire behind unfinished head", int'(cmt_valid), 0);
      read_reg(3'd3, v);
      check("R4", "reg3 held", v, 0);
      do_cmp(t1, 16'h00A1, 1'b0);
      #1 check("R5", "still no retire", int'(cmt_valid), 0);
      read_reg(3'd2, v);
      check("R4", "reg2 held", v, 0);
      do_cmp(t0, 16'h00A0, 1'b0);
      #1;
      check("R6", "cmt_valid head", int'(cmt_valid), 1);
      check("R6", "cmt_tag head", int'(cmt_tag), 0);
      check("R6", "cmt_dest head", int'(cmt_dest), 1);
      check("R6", "cmt_data head", int'(cmt_data), 16'h00A0);
      step(); #1;
      check("R6", "second retire tag", int'(cmt_tag), 1);
      check("R6", "second retire valid", int'(cmt_valid), 1);
      step(); #1;
      check("R6", "third retire tag", int'(cmt_tag), 2);
      step(); #1;
      check("R6", "idle after drain", int'(cmt_valid), 0);
      read_reg(3'd1, v); check("R6", "reg1", v, 16'h00A0);
      read_reg(3'd2, v); check("R6", "reg2", v, 16'h00A1);
      read_reg(3'd3, v); check("R6", "reg3", v, 16'h00A2);
   endtask

   task automatic t_full();
      logic [TAG_W-1:0] tg [8];
      logic [TAG_W-1:0] extra;
      int cnt = 0;
      int v;
      for (int i = 0; i < 8; i++) do_disp(3'd4, 1'b0, tg[i]);
      check("R2", "wrapped tag 5", int'(tg[5]), 0);
      #1 check("R3", "full after DEPTH", int'(disp_full), 1);
      do_disp(3'd5, 1'b0, extra);
      #1;
      check("R3", "tag frozen when full", int'(disp_tag), 3);
      check("R3", "still full", int'(disp_full), 1);
      for (int i = 7; i >= 1; i--) do_cmp(tg[i], DATA_W'(16'h0100 + i), 1'b0);
      #1 check("R5", "reverse completion no retire", int'(cmt_valid), 0);
      do_cmp(tg[0], 16'h0100, 1'b0);
      for (int k = 0; k < 10; k++) begin
         #1 if (cmt_valid) cnt++;
         step();
      end
      check("R3", "retire count", cnt, 8);
      read_reg(3'd4, v); check("R6", "last writer wins", v, 16'h0107);
      read_reg(3'd5, v); check("R3", "refused dispatch never wrote", v, 0);
   endtask

   task automatic t_masked_fault();
      logic [TAG_W-1:0] t;
      int v;
      do_disp(3'd5, 1'b0, t);
      do_cmp(t, 16'h0055, 1'b1);
      #1;
      check("R8", "masked fault no trap", int'(trap_o), 0);
      check("R8", "masked fault retires", int'(cmt_valid), 1);
      step();
      read_reg(3'd5, v); check("R8", "masked fault result written", v, 16'h0055);
   endtask

   task automatic t_precise_trap();
      logic [TAG_W-1:0] ta, tb, tc;
      int v;
      do_disp(3'd0, 1'b1, ta);
      do_disp(3'd6, 1'b0, tb);
      do_disp(3'd7, 1'b0, tc);
      do_cmp(tb, 16'h0066, 1'b1);
      #1;
      check("R11", "young fault waits", int'(trap_o), 0);
      check("R11", "no retire", int'(cmt_valid), 0);
      do_cmp(tc, 16'h0077, 1'b0);
      do_cmp(ta, 16'h0001, 1'b0);
      #1;
      check("R7", "mask op retiring", int'(cmt_valid), 1);
      check("R7", "mask op tag", int'(cmt_tag), int'(ta));
      check("R7", "flag unchanged before edge", int'(trap_en_o), 0);
      step(); #1;
      check("R7", "flag set at retire", int'(trap_en_o), 1);
      check("R11", "trap raised", int'(trap_o), 1);
      check("R9", "trap tag", int'(trap_tag), int'(tb));
      check("R9", "no retire on trap", int'(cmt_valid), 0);
      disp_valid = 1'b1; disp_dest = 3'd2; disp_kind = 1'b0;
      step();
      disp_valid = 1'b0;
      #1;
      check("R9", "trap one cycle", int'(trap_o), 0);
      check("R10", "dispatch during trap ignored", int'(disp_tag), 0);
      check("R9", "nothing retires after flush", int'(cmt_valid), 0);
      read_reg(3'd6, v); check("R9", "faulting result not written", v, 0);
      read_reg(3'd7, v); check("R9", "younger result discarded", v, 0);
      step(); #1;
      check("R9", "still idle", int'(cmt_valid), 0);
   endtask

   task automatic t_mask_off();
      logic [TAG_W-1:0] t;
      do_disp(3'd0, 1'b1, t);
      check("R9", "tags restart at zero", int'(t), 0);
      do_cmp(t, 16'h0000, 1'b0);
      #1 check("R7", "flag holds until retire edge", int'(trap_en_o), 1);
      step(); #1;
      check("R7", "flag cleared at retire", int'(trap_en_o), 0);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      step();
      t_inorder();
      t_full();
      t_masked_fault();
      t_precise_trap();
      t_mask_off();
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule